// File: doc/BRIEF.md
# Pointer and Stack Memory Access Unit

This block sequences the memory instructions of a small 16-bit processor that address memory through an implicit pointer rather than through an address field. It holds two pointers: a general memory pointer and a descending stack pointer. When a decoded operation arrives, the unit issues one request to a synchronous single-port memory and adjusts the pointer that the operation uses. For loads and pops, it then hands the returned word back to the register file.

Pointer-relative operations address memory with the pointer value held before the operation. After the access, the pointer moves by the instruction's signed 8-bit offset. Push lowers the stack pointer first and then writes at the lowered address. Pop reads at the current stack pointer and then raises it. The memory is word-organised with 8-bit byte lanes, and byte operations always use lane 0. The memory has one cycle of read latency, so a load or pop stalls the issuing side for one cycle. The surrounding core can overwrite either pointer directly, for example when an immediate is loaded into a pointer.

Top module: `ptr_mem_unit`

## Requirements
- R1: Operation encoding on `op_code`: 1 word load via pointer, 2 word store via pointer, 3 byte load via pointer, 4 byte store via pointer, 5 push, 6 pop. Codes 0 and 7 are ignored: no pointer change, `mem_we` and `busy` stay 0, and `done` is not raised.
- R2: An accepted word load drives `mem_addr` with the pointer value from before the operation. The pointer becomes that value plus the sign-extended offset. In the `done` cycle, `wb_data` equals the full memory word.
- R3: An accepted word store writes `op_reg` to the old pointer address with `mem_be` = 2'b11. The pointer then moves by the sign-extended offset.
- R4: A byte load returns `wb_data[7:0]` from memory bits 7:0 and `wb_data[15:8]` from `op_reg[15:8]` (the target register's current value, supplied with the operation). The pointer moves as in R2.
- R5: A byte store asserts `mem_be` = 2'b01, so only bits 7:0 of the word change, and those bits take `op_reg[7:0]`. The pointer moves as in R3.
- R6: Push lowers the stack pointer by 1 and writes `op_reg` to the lowered address with both lanes enabled.
- R7: Pop reads at the current stack pointer, returns the word on `wb_data`, and raises the stack pointer by 1.
- R8: The memory request appears on the memory ports in the cycle after acceptance, and the pointer update is visible in that same cycle. A load or pop holds `busy` high for exactly that one cycle. `done` is high in the following cycle, when `wb_data` is valid. An operation presented while `busy` is high is ignored. Stores and pushes never raise `busy` or `done`.
- R9: All pointer arithmetic wraps modulo 2^16.
- R10: `mptr_set` or `sp_set` loads the corresponding pointer, and takes priority over an update from an operation accepted in the same cycle. That operation still uses the old pointer value as its address.
- R11: After reset, both pointers are 0 and `busy`, `done` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_code | input | 3 | Operation code (see R1) |
| op_reg | input | 16 | Source register value, or target register's current value for a byte load |
| op_off | input | 8 | Signed pointer offset for pointer operations |
| mptr_set | input | 1 | Load memory pointer directly |
| mptr_set_val | input | 16 | Value for `mptr_set` |
| sp_set | input | 1 | Load stack pointer directly |
| sp_set_val | input | 16 | Value for `sp_set` |
| mptr | output | 16 | Current memory pointer |
| sp | output | 16 | Current stack pointer |
| busy | output | 1 | Read in flight; operations are not accepted |
| done | output | 1 | Register write-back this cycle |
| wb_data | output | 16 | Write-back value |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 2 | Byte-lane enables |
| mem_rdata | input | 16 | Memory read data, one cycle after the request |

## Verification
The hardest situation to reach from the ports is the collision case. In it, a second operation is held on the inputs during the busy cycle of a load, or a direct pointer write lands in the same cycle as an operation that also moves that pointer. Directed sequences build both cases on purpose: a store is held through the busy cycle, and a set is issued in the same cycle as a load. Wrap-around at the top and bottom of the 16-bit space is also driven directly, by setting a pointer to its extreme value before a push, pop or offset access. Random mixes of all eight codes, with random offsets and occasional pointer sets, run against a shadow memory and shadow pointers kept by the bench.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [2:0] {
        PMU_NOP  = 3'd0,
        PMU_LDW  = 3'd1,
        PMU_STW  = 3'd2,
        PMU_LDB  = 3'd3,
        PMU_STB  = 3'd4,
        PMU_PUSH = 3'd5,
        PMU_POP  = 3'd6,
        PMU_RSV  = 3'd7
    } pmu_op_e;

endpackage

// File: rtl/pmu_ptr_calc.sv
module pmu_ptr_calc
    import pmu_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int OFF_W = 8
) (
    input  logic [2:0]       op_code,
    input  logic [PTR_W-1:0] mptr_cur,
    input  logic [PTR_W-1:0] sp_cur,
    input  logic [OFF_W-1:0] off,
    output logic [PTR_W-1:0] mptr_nxt,
    output logic [PTR_W-1:0] sp_nxt,
    output logic [PTR_W-1:0] acc_addr,
    output logic             legal,
    output logic             is_load,
    output logic             is_store,
    output logic             is_byte,
    output logic             upd_mptr,
    output logic             upd_sp
);
    localparam int EXT_W = PTR_W - OFF_W;

    logic [PTR_W-1:0] off_ext;
    logic [PTR_W-1:0] mptr_adj;
    logic [PTR_W-1:0] sp_dec;
    logic [PTR_W-1:0] sp_inc;

    // adders wrap naturally at PTR_W bits
    assign off_ext  = {{EXT_W{off[OFF_W-1]}}, off};
    assign mptr_adj = mptr_cur + off_ext;
    assign sp_dec   = sp_cur - PTR_W'(1);
    assign sp_inc   = sp_cur + PTR_W'(1);

    always_comb begin
        mptr_nxt = mptr_cur;
        sp_nxt   = sp_cur;
        acc_addr = mptr_cur;
        legal    = 1'b0;
        is_load  = 1'b0;
        is_store = 1'b0;
        is_byte  = 1'b0;
        upd_mptr = 1'b0;
        upd_sp   = 1'b0;
        case (pmu_op_e'(op_code))
            PMU_LDW, PMU_LDB: begin
                legal    = 1'b1;
                is_load  = 1'b1;
                is_byte  = (pmu_op_e'(op_code) == PMU_LDB);
                upd_mptr = 1'b1;
                mptr_nxt = mptr_adj;
            end
            PMU_STW, PMU_STB: begin
                legal    = 1'b1;
                is_store = 1'b1;
                is_byte  = (pmu_op_e'(op_code) == PMU_STB);
                upd_mptr = 1'b1;
                mptr_nxt = mptr_adj;
            end
            PMU_PUSH: begin
                legal    = 1'b1;
                is_store = 1'b1;
                upd_sp   = 1'b1;
                sp_nxt   = sp_dec;
                acc_addr = sp_dec;
            end
            PMU_POP: begin
                legal    = 1'b1;
                is_load  = 1'b1;
                upd_sp   = 1'b1;
                sp_nxt   = sp_inc;
                acc_addr = sp_cur;
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pmu_lane_merge.sv
module pmu_lane_merge #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] hold,
    input  logic              byte_sel,
    output logic [DATA_W-1:0] wb
);
    localparam int LANES = DATA_W / LANE_W;

    // lane 0 always comes from memory; upper lanes keep the old register
    // contents on a byte load
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic keep;
        assign keep = byte_sel && (g != 0);
        assign wb[g*LANE_W +: LANE_W] = keep ? hold[g*LANE_W +: LANE_W]
                                             : rdata[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/ptr_mem_unit.sv
module ptr_mem_unit
    import pmu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 16,
    parameter int OFF_W  = 8,
    parameter int LANE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [2:0]                  op_code,
    input  logic [DATA_W-1:0]           op_reg,
    input  logic [OFF_W-1:0]            op_off,
    input  logic                        mptr_set,
    input  logic [PTR_W-1:0]            mptr_set_val,
    input  logic                        sp_set,
    input  logic [PTR_W-1:0]            sp_set_val,
    output logic [PTR_W-1:0]            mptr,
    output logic [PTR_W-1:0]            sp,
    output logic                        busy,
    output logic                        done,
    output logic [DATA_W-1:0]           wb_data,
    output logic [PTR_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic                        mem_we,
    output logic [DATA_W/LANE_W-1:0]    mem_be,
    input  logic [DATA_W-1:0]           mem_rdata
);
    localparam int BE_W = DATA_W / LANE_W;
    localparam logic [BE_W-1:0] BE_ALL  = '1;
    localparam logic [BE_W-1:0] BE_LOW  = BE_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0]  mptr;
        logic [PTR_W-1:0]  sp;
        logic [PTR_W-1:0]  addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
        logic [BE_W-1:0]   be;
        logic              rd_pend;
        logic              rd_ret;
        logic              rd_byte;
        logic [DATA_W-1:0] hold;
    } pmu_state_t;

    pmu_state_t st_d, st_q;

    logic [PTR_W-1:0] c_mptr_nxt, c_sp_nxt, c_addr;
    logic             c_legal, c_load, c_store, c_byte, c_upd_mptr, c_upd_sp;
    logic             accept;

    pmu_ptr_calc #(
        .PTR_W (PTR_W),
        .OFF_W (OFF_W)
    ) u_calc (
        .op_code  (op_code),
        .mptr_cur (st_q.mptr),
        .sp_cur   (st_q.sp),
        .off      (op_off),
        .mptr_nxt (c_mptr_nxt),
        .sp_nxt   (c_sp_nxt),
        .acc_addr (c_addr),
        .legal    (c_legal),
        .is_load  (c_load),
        .is_store (c_store),
        .is_byte  (c_byte),
        .upd_mptr (c_upd_mptr),
        .upd_sp   (c_upd_sp)
    );

    pmu_lane_merge #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_merge (
        .rdata    (mem_rdata),
        .hold     (st_q.hold),
        .byte_sel (st_q.rd_byte),
        .wb       (wb_data)
    );

    assign accept = op_valid && !st_q.rd_pend && c_legal;

    always_comb begin
        st_d         = st_q;
        st_d.we      = 1'b0;
        st_d.be      = '0;
        st_d.rd_pend = 1'b0;
        st_d.rd_ret  = st_q.rd_pend;
        if (accept) begin
            st_d.addr    = c_addr;
            st_d.we      = c_store;
            st_d.be      = c_byte ? BE_LOW : BE_ALL;
            st_d.wdata   = c_byte ? DATA_W'(op_reg[LANE_W-1:0]) : op_reg;
            st_d.rd_pend = c_load;
            st_d.rd_byte = c_byte;
            st_d.hold    = op_reg;
            if (c_upd_mptr) st_d.mptr = c_mptr_nxt;
            if (c_upd_sp)   st_d.sp   = c_sp_nxt;
        end
        if (mptr_set) st_d.mptr = mptr_set_val;
        if (sp_set)   st_d.sp   = sp_set_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mptr      = st_q.mptr;
    assign sp        = st_q.sp;
    assign busy      = st_q.rd_pend;
    assign done      = st_q.rd_ret;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = st_q.wdata;
    assign mem_we    = st_q.we;
    assign mem_be    = st_q.be;

    // R8
    busy_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R8
    done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> done);

    // R8
    done_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R3
    write_has_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be != '0) && !busy && !done);

    // R6
    push_addr_is_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == PMU_PUSH && !sp_set) |=> (mem_we && mem_addr == sp));

    // R7
    pop_addr_old_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_code == PMU_POP && !sp_set) |=> (busy && mem_addr == $past(sp)));

    // R1
    ignored_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && (op_code == PMU_NOP || op_code == PMU_RSV) && !mptr_set && !sp_set)
        |=> (!mem_we && !busy && $stable(mptr) && $stable(sp)));

endmodule

// File: tb/ptr_mem_unit_test.sv
`timescale 1ns/1ps
module ptr_mem_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [15:0] op_reg;
    logic [7:0]  op_off;
    logic        mptr_set;
    logic [15:0] mptr_set_val;
    logic        sp_set;
    logic [15:0] sp_set_val;
    logic [15:0] mptr, sp;
    logic        busy, done;
    logic [15:0] wb_data, mem_addr, mem_wdata;
    logic        mem_we;
    logic [1:0]  mem_be;
    logic [15:0] mem_rdata;

    int vectors = 0;
    int fails   = 0;

    logic [15:0] model_mem  [256];
    logic [15:0] shadow_mem [256];
    logic [15:0] r_mptr, r_sp;

    always #2.5 clk = ~clk;

    ptr_mem_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_reg(op_reg), .op_off(op_off), .mptr_set(mptr_set),
        .mptr_set_val(mptr_set_val), .sp_set(sp_set), .sp_set_val(sp_set_val),
        .mptr(mptr), .sp(sp), .busy(busy), .done(done), .wb_data(wb_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_be(mem_be), .mem_rdata(mem_rdata)
    );

    // synchronous memory model, one cycle read latency
    always @(posedge clk) begin
        mem_rdata <= model_mem[mem_addr[7:0]];
        if (mem_we) begin
            if (mem_be[0]) model_mem[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) model_mem[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [15:0] sext(input logic [7:0] o);
        return {{8{o[7]}}, o};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic set_ptrs(input bit sm, input logic [15:0] vm,
                            input bit ss, input logic [15:0] vs);
        @(negedge clk);
        mptr_set = sm; mptr_set_val = vm;
        sp_set = ss;   sp_set_val = vs;
        @(negedge clk);
        mptr_set = 1'b0; sp_set = 1'b0;
        if (sm) r_mptr = vm;
        if (ss) r_sp = vs;
        chk(mptr == r_mptr, "R10", mptr, r_mptr, "mptr after set");
        chk(sp == r_sp, "R10", sp, r_sp, "sp after set");
    endtask

    task automatic do_op(input logic [2:0] c, input logic [15:0] rv,
                         input logic [7:0] off);
        logic [15:0] e_addr, e_wb;
        bit ld, st, by, legal;
        string rq;
        rq = req_of(c);
        ld = (c == 3'd1) || (c == 3'd3) || (c == 3'd6);
        st = (c == 3'd2) || (c == 3'd4) || (c == 3'd5);
        by = (c == 3'd3) || (c == 3'd4);
        legal = ld || st;
        e_addr = r_mptr;
        @(negedge clk);
        op_valid = 1'b1; op_code = c; op_reg = rv; op_off = off;
        @(negedge clk);
        op_valid = 1'b0;
        case (c)
            3'd1, 3'd2, 3'd3, 3'd4: begin e_addr = r_mptr; r_mptr = r_mptr + sext(off); end
            3'd5: begin r_sp = r_sp - 16'd1; e_addr = r_sp; end
            3'd6: begin e_addr = r_sp; r_sp = r_sp + 16'd1; end
            default: ;
        endcase
        chk(mptr == r_mptr, rq, mptr, r_mptr, "mptr");
        chk(sp == r_sp, rq, sp, r_sp, "sp");
        chk(mem_we == st, rq, mem_we, st, "mem_we");
        chk(busy == ld, "R8", busy, ld, "busy");
        if (legal) begin
            chk(mem_addr == e_addr, rq, mem_addr, e_addr, "mem_addr");
            chk(mem_be == (by ? 2'b01 : 2'b11), rq, mem_be, (by ? 2'b01 : 2'b11), "mem_be");
        end
        if (st) begin
            if (by) begin
                chk(mem_wdata[7:0] == rv[7:0], rq, mem_wdata[7:0], rv[7:0], "byte wdata");
                shadow_mem[e_addr[7:0]][7:0] = rv[7:0];
            end else begin
                chk(mem_wdata == rv, rq, mem_wdata, rv, "wdata");
                shadow_mem[e_addr[7:0]] = rv;
            end
        end
        @(negedge clk);
        if (ld) begin
            e_wb = by ? {rv[15:8], shadow_mem[e_addr[7:0]][7:0]} : shadow_mem[e_addr[7:0]];
            chk(done == 1'b1, "R8", done, 1, "done");
            chk(wb_data == e_wb, rq, wb_data, e_wb, "wb_data");
            chk(busy == 1'b0, "R8", busy, 0, "busy after read");
        end else begin
            chk(done == 1'b0, legal ? "R8" : "R1", done, 0, "done");
            chk(busy == 1'b0, legal ? "R8" : "R1", busy, 0, "busy");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i]  = 16'(i * 16'h0101) ^ 16'h5a3c;
            shadow_mem[i] = 16'(i * 16'h0101) ^ 16'h5a3c;
        end
        void'($urandom(32'd7321));
        rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; op_reg = '0; op_off = '0;
        mptr_set = 1'b0; mptr_set_val = '0; sp_set = 1'b0; sp_set_val = '0;
        r_mptr = '0; r_sp = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(mptr == 16'h0, "R11", mptr, 0, "reset mptr");
        chk(sp == 16'h0, "R11", sp, 0, "reset sp");
        chk(busy == 1'b0 && done == 1'b0, "R11", {busy, done}, 0, "reset busy/done");
        chk(mem_we == 1'b0, "R11", mem_we, 0, "reset mem_we");
        rst_n = 1'b1;

        // R2 R3 word store then load back
        set_ptrs(1'b1, 16'h0020, 1'b1, 16'h0080);
        do_op(3'd2, 16'hbeef, 8'h03);
        set_ptrs(1'b1, 16'h0020, 1'b0, 16'h0);
        do_op(3'd1, 16'h0000, 8'hfe);
        // R5 then R4: byte store, byte load keeps upper bits
        do_op(3'd4, 16'h12c7, 8'h01);
        set_ptrs(1'b1, 16'h001e, 1'b0, 16'h0);
        do_op(3'd3, 16'ha500, 8'h00);
        // R6 R7 push/pop pair
        do_op(3'd5, 16'h4242, 8'h00);
        do_op(3'd5, 16'h1357, 8'h00);
        do_op(3'd6, 16'h0000, 8'h00);
        do_op(3'd6, 16'h0000, 8'h00);
        // R1 ignored codes
        do_op(3'd0, 16'hffff, 8'h7f);
        do_op(3'd7, 16'hffff, 8'h80);
        // R9 wrap
        set_ptrs(1'b1, 16'hffff, 1'b1, 16'h0000);
        do_op(3'd1, 16'h0, 8'h01);
        chk(mptr == 16'h0000, "R9", mptr, 0, "mptr wrap up");
        do_op(3'd2, 16'h0bad, 8'h80);
        chk(mptr == 16'hff80, "R9", mptr, 16'hff80, "mptr wrap down");
        do_op(3'd5, 16'h7777, 8'h00);
        chk(sp == 16'hffff, "R9", sp, 16'hffff, "sp wrap down");
        do_op(3'd6, 16'h0, 8'h00);
        chk(sp == 16'h0000, "R9", sp, 0, "sp wrap up");

        // R8 operation held during busy is ignored
        set_ptrs(1'b1, 16'h0010, 1'b0, 16'h0);
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; op_reg = '0; op_off = 8'h02;
        @(negedge clk);
        chk(busy == 1'b1, "R8", busy, 1, "busy during read");
        op_code = 3'd2; op_reg = 16'hdead; op_off = 8'h05;
        @(negedge clk);
        op_valid = 1'b0;
        r_mptr = 16'h0012;
        chk(mptr == 16'h0012, "R8", mptr, 16'h0012, "held op ignored mptr");
        chk(mem_we == 1'b0, "R8", mem_we, 0, "held op ignored we");
        chk(done == 1'b1, "R8", done, 1, "done after busy");
        chk(wb_data == shadow_mem[8'h10], "R8", wb_data, shadow_mem[8'h10], "held op wb");

        // R10 set wins over same-cycle update; access uses old pointer
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; op_off = 8'h04;
        mptr_set = 1'b1; mptr_set_val = 16'h0040;
        @(negedge clk);
        op_valid = 1'b0; mptr_set = 1'b0;
        chk(mptr == 16'h0040, "R10", mptr, 16'h0040, "set priority");
        chk(mem_addr == 16'h0012, "R10", mem_addr, 16'h0012, "old pointer used");
        r_mptr = 16'h0040;
        @(negedge clk);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0] c;
            c = 3'($urandom % 8);
            if (($urandom % 16) == 0)
                set_ptrs(1'b1, 16'($urandom), ($urandom % 2) == 1, 16'($urandom));
            do_op(c, 16'($urandom), 8'($urandom));
        end

        summary();
        $finish;
    end

endmodule